// File: doc/BRIEF.md
# Short-Address DMA Channel Controller

This block is a single DMA channel that works in short-address mode. Each transfer moves one byte or one 16-bit word between a memory location and one fixed I/O location. The memory location is held in a memory address register, and the I/O location is fixed. A transfer starts when the peripheral event chosen by an 8-bit control register fires. After each transfer the channel steps the memory address and counts down a 16-bit transfer counter. When the counter runs out, the channel does one of three things, depending on the mode bits: it stops and may raise an interrupt, it reloads and keeps running, or it keeps the address fixed and reloads only the count.

Software writes the memory address and the transfer count first. Each write also stores a reload copy. Software then writes the control register with the enable bit set. On the bus side there are two handshake signals. The channel raises a one-cycle request that carries the memory address, the transfer size and the direction. The bus answers with a done pulse when the transfer has completed.

Top module: `dma_short_ch`

## Requirements
- R1: After a synchronous reset, the control register reads 0x00, and both `bus_req` and `irq` are low.
- R2: All eight control bits can be written and read back. Bit 7 is the enable, bit 6 the size (1 = word), bit 5 the direction of stepping (1 = decrement), bit 4 repeat, bit 3 interrupt enable, and bits 2:0 the activation source.
- R3: While the enable bit is 0, no peripheral event starts a transfer.
- R4: Source codes 0 to 3 select timer events 0 to 3. Code 4 selects serial transmit-empty. Code 5 selects serial receive-full. An event on a source that is not selected has no effect.
- R5: Source codes 6 and 7 never start a short-address transfer.
- R6: After each transfer the memory address moves by 1 for a byte transfer and by 2 for a word transfer. It moves up when bit 5 is 0 and down when bit 5 is 1.
- R7: Each transfer raises `bus_req` for exactly one cycle. While `bus_req` is high, `bus_addr` holds the memory address and `bus_word` holds the size. `bus_dir` is 1 (I/O to memory) only for source code 5. The transfer completes when `bus_done` is seen.
- R8: Events that arrive while a transfer is in progress are kept as a single pending level. Any number of such events produces exactly one further transfer.
- R9: In I/O mode (repeat = 0), the transfer that brings the count to zero clears the enable bit. If interrupt enable is 1, that transfer also pulses `irq` for one cycle.
- R10: When interrupt enable is 0, the end of a block raises no `irq`. No mode other than I/O ever raises `irq`.
- R11: In repeat mode (repeat = 1, interrupt enable = 0), the address and the count reload their written values when the count reaches zero. The enable bit stays set.
- R12: In idle mode (repeat = 1, interrupt enable = 1), the memory address never changes. The count reloads at zero and the channel stays enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents |
| mar_we | input | 1 | Memory address write strobe (also sets the reload value) |
| mar_wdata | input | 24 | Memory address write data |
| cnt_we | input | 1 | Transfer count write strobe (also sets the reload value) |
| cnt_wdata | input | 16 | Transfer count write data |
| timer_evt | input | 4 | Compare/capture event pulses of timers 0 to 3 |
| sci_txe | input | 1 | Serial transmit-empty event |
| sci_rxf | input | 1 | Serial receive-full event |
| bus_req | output | 1 | One-cycle transfer request |
| bus_addr | output | 24 | Memory address of the current transfer |
| bus_word | output | 1 | 1 = word transfer, 0 = byte transfer |
| bus_dir | output | 1 | 1 = I/O to memory, 0 = memory to I/O |
| bus_done | input | 1 | Bus has finished the requested transfer |
| irq | output | 1 | End-of-block interrupt pulse |

## Verification
The hardest case to reach is an activation that lands while a transfer is still waiting for `bus_done`. It has to be kept as exactly one pending level, not dropped and not counted twice. The stimulus holds a timer event high for three consecutive cycles. The later pulses then fall into the request and wait states, and the scoreboard expects exactly two transfers. A second hard case is the count reaching zero in each of the three end-of-block modes. Short counts of one or two are loaded so that the reload and the clearing of the enable bit can be seen within a few events.

// File: rtl/dma_sa_pkg.sv
package dma_sa_pkg;

    localparam int CFG_W = 8;
    localparam int SRC_W = 3;

    typedef struct packed {
        logic             en;
        logic             word;
        logic             dec;
        logic             rpt;
        logic             ie;
        logic [SRC_W-1:0] src;
    } cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } xfer_st_t;

    typedef enum logic [1:0] {
        MD_IO     = 2'd0,
        MD_REPEAT = 2'd1,
        MD_HOLD   = 2'd2
    } blk_mode_t;

    function automatic blk_mode_t mode_of(cfg_t c);
        if (!c.rpt)
            return MD_IO;
        else if (!c.ie)
            return MD_REPEAT;
        else
            return MD_HOLD;
    endfunction

    // Step size: 1 for byte, 2 for word; sign picked by dec
    function automatic logic [23:0] step_addr(logic [23:0] a, logic word, logic dec);
        logic [23:0] d;
        d = word ? 24'd2 : 24'd1;
        return dec ? (a - d) : (a + d);
    endfunction

endpackage

// File: rtl/dma_sa_cfg.sv
module dma_sa_cfg
    import dma_sa_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             hw_clr_en,
    output cfg_t             cfg
);

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= cfg_t'(wdata);
        end else if (hw_clr_en) begin
            cfg_q.en <= 1'b0;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/dma_sa_srcsel.sv
module dma_sa_srcsel
    import dma_sa_pkg::*;
#(
    parameter int NTMR = 4
) (
    input  logic [SRC_W-1:0] src,
    input  logic [NTMR-1:0]  timer_evt,
    input  logic             sci_txe,
    input  logic             sci_rxf,
    output logic             hit,
    output logic             valid,
    output logic             to_mem
);

    localparam int CODE_TXE = NTMR;
    localparam int CODE_RXF = NTMR + 1;
    localparam int NSRC     = NTMR + 2;

    logic [NTMR-1:0] tmr_hit;

    for (genvar i = 0; i < NTMR; i++) begin : g_tmr
        assign tmr_hit[i] = timer_evt[i] && (src == SRC_W'(i));
    end

    always_comb begin
        hit = |tmr_hit;
        if (src == SRC_W'(CODE_TXE) && sci_txe) hit = 1'b1;
        if (src == SRC_W'(CODE_RXF) && sci_rxf) hit = 1'b1;
    end

    assign valid  = (32'(src) < NSRC);
    assign to_mem = (src == SRC_W'(CODE_RXF));

endmodule

// File: rtl/dma_sa_engine.sv
module dma_sa_engine
    import dma_sa_pkg::*;
#(
    parameter int AW = 24,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  cfg_t          cfg,
    input  logic          hit,
    input  logic          valid,
    input  logic          to_mem,
    input  logic          mar_we,
    input  logic [AW-1:0] mar_wdata,
    input  logic          cnt_we,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          bus_done,
    output logic          bus_req,
    output logic [AW-1:0] bus_addr,
    output logic          bus_word,
    output logic          bus_dir,
    output logic          irq,
    output logic          clr_en
);

    xfer_st_t      st_q;
    logic          pend_q;
    logic [AW-1:0] mar_q, mar_init_q;
    logic [CW-1:0] cnt_q, cnt_init_q;
    logic          dir_q, irq_q;

    blk_mode_t     mode;
    logic          start, finish, last;
    logic [CW-1:0] cnt_dec;
    logic [23:0]   stepped;

    assign mode    = mode_of(cfg);
    assign start   = (st_q == ST_IDLE) && cfg.en && valid && (hit || pend_q);
    assign finish  = (st_q == ST_WAIT) && bus_done;
    assign cnt_dec = cnt_q - CW'(1);
    assign last    = (cnt_dec == '0);
    assign stepped = step_addr(24'(mar_q), cfg.word, cfg.dec);
    assign clr_en  = finish && last && (mode == MD_IO);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start)    st_q <= ST_REQ;
                ST_REQ:                st_q <= ST_WAIT;
                ST_WAIT: if (bus_done) st_q <= ST_IDLE;
                default:               st_q <= ST_IDLE;
            endcase
        end
    end

    // Single-level pending activation
    always_ff @(posedge clk) begin
        if (rst || !cfg.en || !valid) begin
            pend_q <= 1'b0;
        end else if (st_q == ST_IDLE) begin
            if (start) pend_q <= 1'b0;
        end else if (hit) begin
            pend_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= 1'b0;
        end else if (start) begin
            dir_q <= to_mem;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mar_q      <= '0;
            mar_init_q <= '0;
        end else if (mar_we) begin
            mar_q      <= mar_wdata;
            mar_init_q <= mar_wdata;
        end else if (finish) begin
            unique case (mode)
                MD_IO:     mar_q <= AW'(stepped);
                MD_REPEAT: mar_q <= last ? mar_init_q : AW'(stepped);
                default:   mar_q <= mar_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            cnt_init_q <= '0;
        end else if (cnt_we) begin
            cnt_q      <= cnt_wdata;
            cnt_init_q <= cnt_wdata;
        end else if (finish) begin
            cnt_q <= (last && mode != MD_IO) ? cnt_init_q : cnt_dec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= clr_en && cfg.ie;
    end

    assign bus_req  = (st_q == ST_REQ);
    assign bus_addr = mar_q;
    assign bus_word = cfg.word;
    assign bus_dir  = dir_q;
    assign irq      = irq_q;

endmodule

// File: rtl/dma_short_ch.sv
module dma_short_ch
    import dma_sa_pkg::*;
#(
    parameter int AW   = 24,
    parameter int CW   = 16,
    parameter int NTMR = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             mar_we,
    input  logic [AW-1:0]    mar_wdata,
    input  logic             cnt_we,
    input  logic [CW-1:0]    cnt_wdata,
    input  logic [NTMR-1:0]  timer_evt,
    input  logic             sci_txe,
    input  logic             sci_rxf,
    output logic             bus_req,
    output logic [AW-1:0]    bus_addr,
    output logic             bus_word,
    output logic             bus_dir,
    input  logic             bus_done,
    output logic             irq
);

    cfg_t cfg;
    logic hit, valid, to_mem, clr_en;

    dma_sa_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .wdata     (cfg_wdata),
        .hw_clr_en (clr_en),
        .cfg       (cfg)
    );

    dma_sa_srcsel #(.NTMR(NTMR)) u_src (
        .src       (cfg.src),
        .timer_evt (timer_evt),
        .sci_txe   (sci_txe),
        .sci_rxf   (sci_rxf),
        .hit       (hit),
        .valid     (valid),
        .to_mem    (to_mem)
    );

    dma_sa_engine #(.AW(AW), .CW(CW)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .hit       (hit),
        .valid     (valid),
        .to_mem    (to_mem),
        .mar_we    (mar_we),
        .mar_wdata (mar_wdata),
        .cnt_we    (cnt_we),
        .cnt_wdata (cnt_wdata),
        .bus_done  (bus_done),
        .bus_req   (bus_req),
        .bus_addr  (bus_addr),
        .bus_word  (bus_word),
        .bus_dir   (bus_dir),
        .irq       (irq),
        .clr_en    (clr_en)
    );

    assign cfg_rdata = CFG_W'(cfg);

endmodule

// File: rtl/dma_short_ch_chk.sv
module dma_short_ch_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst,
    input logic [7:0]    cfg_rdata,
    input logic          bus_req,
    input logic          irq,
    input logic          mar_we,
    input logic [AW-1:0] bus_addr
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (cfg_rdata == 8'h00 && !bus_req && !irq));

    // R3
    off_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_rdata[7] |=> !bus_req);

    // R5
    full_mode_code_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[2:1] == 2'b11) |=> !bus_req);

    // R7
    req_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req |=> !bus_req);

    // R10
    irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(cfg_rdata[3]) && !$past(cfg_rdata[4])));

    // R12
    hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[4] && cfg_rdata[3] && !mar_we) |=> $stable(bus_addr));

endmodule

bind dma_short_ch dma_short_ch_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_rdata (cfg_rdata),
    .bus_req   (bus_req),
    .irq       (irq),
    .mar_we    (mar_we),
    .bus_addr  (bus_addr)
);

// File: tb/dma_short_ch_tb.sv
module dma_short_ch_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        mar_we = 1'b0;
    logic [23:0] mar_wdata = '0;
    logic        cnt_we = 1'b0;
    logic [15:0] cnt_wdata = '0;
    logic [3:0]  timer_evt = '0;
    logic        sci_txe = 1'b0;
    logic        sci_rxf = 1'b0;
    logic        bus_req;
    logic [23:0] bus_addr;
    logic        bus_word;
    logic        bus_dir;
    logic        bus_done = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int xfers  = 0;
    int irqs   = 0;

    logic [25:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    dma_short_ch u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .mar_we(mar_we), .mar_wdata(mar_wdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .timer_evt(timer_evt),
        .sci_txe(sci_txe), .sci_rxf(sci_rxf), .bus_req(bus_req),
        .bus_addr(bus_addr), .bus_word(bus_word), .bus_dir(bus_dir),
        .bus_done(bus_done), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected items as requests appear, answers with done
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && bus_req) begin
                xfers++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected request addr", int'(bus_addr), 0);
                end else begin
                    logic [25:0] e;
                    string       t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({bus_addr, bus_word, bus_dir} == e, t, "transfer {addr,word,dir}",
                          int'({bus_addr, bus_word, bus_dir}), int'(e));
                end
                @(negedge clk);
                bus_done = 1'b1;
                @(negedge clk);
                bus_done = 1'b0;
            end
        end
    end

    always @(negedge clk) if (!rst && irq) irqs++;

    task automatic expect_x(input logic [23:0] a, input logic w, input logic d, input string t);
        exp_q.push_back({a, w, d});
        tag_q.push_back(t);
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic load(input logic [23:0] a, input logic [15:0] c);
        @(negedge clk); mar_we = 1'b1; mar_wdata = a; cnt_we = 1'b1; cnt_wdata = c;
        @(negedge clk); mar_we = 1'b0; cnt_we = 1'b0;
    endtask

    // Pulse the event of a source code for n cycles, then let it settle
    task automatic fire(input int code, input int n);
        @(negedge clk);
        if (code < 4) timer_evt[code] = 1'b1;
        else if (code == 4) sci_txe = 1'b1;
        else if (code == 5) sci_rxf = 1'b1;
        else begin timer_evt = '1; sci_txe = 1'b1; sci_rxf = 1'b1; end
        repeat (n) @(negedge clk);
        timer_evt = '0; sci_txe = 1'b0; sci_rxf = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R1
        check(cfg_rdata == 8'h00, "R1", "cfg after reset", cfg_rdata, 0);
        check(!bus_req && !irq, "R1", "req/irq after reset", {bus_req, irq}, 0);
        rst = 1'b0;

        // R2 readback (source 7 keeps the channel from moving)
        wr_cfg(8'h5A);
        check(cfg_rdata == 8'h5A, "R2", "cfg readback", cfg_rdata, 8'h5A);
        wr_cfg(8'hFF);
        check(cfg_rdata == 8'hFF, "R2", "cfg readback", cfg_rdata, 8'hFF);
        wr_cfg(8'h00);

        // R3: disabled channel ignores its source
        load(24'h001000, 16'd10);
        fire(0, 1);
        check(xfers == 0, "R3", "transfers while disabled", xfers, 0);

        // R4, R6: each source code, byte increment; bit7=en, src in bits 2:0
        base = xfers;
        for (int c = 0; c < 6; c++) begin
            wr_cfg(8'h80 | 8'(c));
            fire((c + 1) % 6, 1); // wrong source, must be ignored
            expect_x(24'h001000 + 24'(c), 1'b0, (c == 5), (c == 5) ? "R7" : "R4");
            fire(c, 1);
        end
        check(xfers - base == 6, "R4", "selected-source transfers", xfers - base, 6);
        check(bus_addr == 24'h001006, "R6", "byte increment address", int'(bus_addr), 24'h001006);

        // R6: word decrement (en, word, dec, src 2)
        wr_cfg(8'hE2);
        expect_x(24'h001006, 1'b1, 1'b0, "R6");
        fire(2, 1);
        expect_x(24'h001004, 1'b1, 1'b0, "R6");
        fire(2, 1);
        check(bus_addr == 24'h001002, "R6", "word decrement address", int'(bus_addr), 24'h001002);

        // R8: three consecutive event cycles -> two transfers
        load(24'h002000, 16'd100);
        wr_cfg(8'h80);
        base = xfers;
        expect_x(24'h002000, 1'b0, 1'b0, "R8");
        expect_x(24'h002001, 1'b0, 1'b0, "R8");
        fire(0, 3);
        check(xfers - base == 2, "R8", "pending merges to one", xfers - base, 2);

        // R9: I/O mode with interrupt enable, count 2
        load(24'h003000, 16'd2);
        wr_cfg(8'h88);
        base = irqs;
        expect_x(24'h003000, 1'b0, 1'b0, "R9");
        fire(0, 1);
        check(irqs == base, "R9", "no irq before block end", irqs - base, 0);
        expect_x(24'h003001, 1'b0, 1'b0, "R9");
        fire(0, 1);
        check(irqs - base == 1, "R9", "irq pulses at block end", irqs - base, 1);
        check(cfg_rdata == 8'h08, "R9", "enable cleared", cfg_rdata, 8'h08);
        base = xfers;
        fire(0, 1);
        check(xfers == base, "R9", "stopped after block end", xfers - base, 0);

        // R10: interrupt enable off
        load(24'h003100, 16'd1);
        wr_cfg(8'h80);
        base = irqs;
        expect_x(24'h003100, 1'b0, 1'b0, "R10");
        fire(0, 1);
        check(irqs == base, "R10", "irq suppressed", irqs - base, 0);
        check(cfg_rdata == 8'h00, "R10", "enable cleared", cfg_rdata, 0);

        // R11: repeat mode, count 2
        load(24'h004000, 16'd2);
        wr_cfg(8'h90);
        base = irqs;
        expect_x(24'h004000, 1'b0, 1'b0, "R11");
        expect_x(24'h004001, 1'b0, 1'b0, "R11");
        expect_x(24'h004000, 1'b0, 1'b0, "R11");
        fire(0, 1); fire(0, 1); fire(0, 1);
        check(cfg_rdata == 8'h90, "R11", "stays enabled", cfg_rdata, 8'h90);
        check(irqs == base, "R10", "no irq in repeat mode", irqs - base, 0);

        // R12: hold mode, word, count 2
        load(24'h005000, 16'd2);
        wr_cfg(8'hD8);
        for (int k = 0; k < 3; k++) begin
            expect_x(24'h005000, 1'b1, 1'b0, "R12");
            fire(0, 1);
        end
        check(cfg_rdata == 8'hD8, "R12", "stays enabled", cfg_rdata, 8'hD8);
        check(irqs == base, "R10", "no irq in hold mode", irqs - base, 0);

        // R5: codes 6 and 7 with every event firing
        base = xfers;
        wr_cfg(8'h86); fire(7, 2);
        wr_cfg(8'h87); fire(7, 2);
        check(xfers == base, "R5", "codes 6/7 inert", xfers - base, 0);

        check(exp_q.size() == 0, "R7", "expected transfers left over", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule